// File: doc/BRIEF.md
# Timer Channel Event Flags and Interrupt Unit

This block holds the event flags and interrupt request of one 16-bit timer/counter channel. The counting, capture and waveform datapath lives elsewhere and reports each event as a one-cycle strobe: counter wrap from 65535 to 0, compare hits on the three compare registers A, B and C, capture loads into registers A and B, an external trigger, and software reads of registers A and B. The unit turns these strobes into sticky flags. A status read clears the flags. They are combined with a software-controlled mask into one interrupt line.

The channel runs either in capture mode (`wave_mode` = 0) or in waveform mode (`wave_mode` = 1), and the mode decides which flags can be raised and which are visible. In capture mode, two small state machines, one per capture register, follow whether a captured value is still unread. A second capture into an unread register raises the overrun flag. Three further status bits show live copies of the counter clock-enable state and of the two channel I/O line levels.

Each tracker has two states, `TRK_IDLE` (no unread capture) and `TRK_PENDING` (a capture is waiting to be read). Its transitions:

- `TRK_IDLE` → `TRK_PENDING` on a load.
- `TRK_PENDING` → `TRK_IDLE` on a read with no load.
- `TRK_PENDING` → `TRK_PENDING` on a load. This raises overrun, unless a read happens in the same cycle.
- `TRK_IDLE` → `TRK_IDLE` otherwise.

Top module: `tcs_event_unit`

## Requirements
- R1: After reset, all sticky flags, the mask and `irq_o` are 0, and both trackers are in `TRK_IDLE`.
- R2: A strobe sets its sticky bit in `status_o` on the clock edge that samples it. The bit then holds until a status read. Bit positions: 0 counter wrap, 1 capture overrun, 2 compare A, 3 compare B, 4 compare C, 5 capture A, 6 capture B, 7 external trigger.
- R3: A `rd_status` pulse clears every sticky bit (0 to 7) at the same edge.
- R4: An event strobe in the same cycle as `rd_status` leaves its bit set after that edge.
- R5: Compare A and B strobes set their bits only in waveform mode, and bits 2 and 3 read 0 while in capture mode.
- R6: Capture A and B strobes set bits 5 and 6, and drive the trackers, only in capture mode. Bits 1, 5 and 6 read 0 while in waveform mode.
- R7: In capture mode, a capture into register A or B while its tracker is in `TRK_PENDING` sets bit 1. This does not happen if the matching read strobe arrives in the same cycle. A read between two captures prevents the overrun.
- R8: `status_o` bits 16, 17 and 18 follow `clk_en_live`, `io_a_lvl` and `io_b_lvl` combinationally, and bits 15 to 8 are 0.
- R9: A 1 in `ien_data` with `ien_wr` sets that mask bit. A 1 in `idis_data` with `idis_wr` clears it, and disable wins if both target the same bit. Zero bits have no effect. `mask_o` shows the mask.
- R10: `irq_o` is high exactly when some visible sticky bit 0 to 7 and its mask bit are both 1.
- R11: Counter wrap, compare C and external trigger set their bits in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 1 | 0 capture mode, 1 waveform mode |
| ev_wrap | input | 1 | Counter wrap strobe |
| ev_cmp_a | input | 1 | Compare A strobe |
| ev_cmp_b | input | 1 | Compare B strobe |
| ev_cmp_c | input | 1 | Compare C strobe |
| ev_cap_a | input | 1 | Capture into A strobe |
| ev_cap_b | input | 1 | Capture into B strobe |
| ev_trig | input | 1 | External trigger strobe |
| rd_a | input | 1 | Software read of register A |
| rd_b | input | 1 | Software read of register B |
| rd_status | input | 1 | Status read (clears sticky bits) |
| clk_en_live | input | 1 | Counter clock enabled, live |
| io_a_lvl | input | 1 | I/O line A level |
| io_b_lvl | input | 1 | I/O line B level |
| ien_wr | input | 1 | Mask set write strobe |
| ien_data | input | 8 | Bits to set in the mask |
| idis_wr | input | 1 | Mask clear write strobe |
| idis_data | input | 8 | Bits to clear in the mask |
| status_o | output | 19 | Status word |
| mask_o | output | 8 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag logic is driven with single events, several events in one cycle, and events that coincide with a status read. These cases separate correct sticky behaviour from plain level-following and from a clear that wins over a set.

Capture sequences come in three kinds:
- load-load, which must overrun;
- load-read-load, which must not;
- load with a read in the same cycle, which must not.

Together these separate a correct tracker from one that ignores reads or counts every load.

The mode is switched while flags are set, which shows mode gating at set time apart from masking at read time. Mask writes with zero bits, and with set and clear on the same bit, check R9 before the interrupt line is tested against masked and unmasked flags.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int EVT_W  = 8;
    localparam int STAT_W = 19;

    localparam int B_WRAP = 0;
    localparam int B_OVR  = 1;
    localparam int B_CMPA = 2;
    localparam int B_CMPB = 3;
    localparam int B_CMPC = 4;
    localparam int B_CAPA = 5;
    localparam int B_CAPB = 6;
    localparam int B_TRIG = 7;
    localparam int B_CKEN = 16;
    localparam int B_IOA  = 17;
    localparam int B_IOB  = 18;

    typedef enum logic {
        TRK_IDLE    = 1'b0,
        TRK_PENDING = 1'b1
    } trk_state_e;
endpackage

// File: rtl/tcs_load_tracker.sv
module tcs_load_tracker
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic read_i,
    output logic overrun_o,
    output logic pending_o
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        overrun_o = 1'b0;
        unique case (state_q)
            TRK_IDLE: begin
                if (load_i) state_d = TRK_PENDING;
            end
            TRK_PENDING: begin
                if (load_i) begin
                    state_d   = TRK_PENDING;
                    overrun_o = !read_i;
                end else if (read_i) begin
                    state_d = TRK_IDLE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    assign pending_o = (state_q == TRK_PENDING);
endmodule

// File: rtl/tcs_flag_bank.sv
module tcs_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flag_o
);
    for (genvar g = 0; g < W; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_o[g] <= 1'b0;
            else if (set_i[g])  flag_o[g] <= 1'b1;
            else if (clr_i)     flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/tcs_irq_mask.sv
module tcs_irq_mask #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [W-1:0] en_bits,
    input  logic         dis_wr,
    input  logic [W-1:0] dis_bits,
    input  logic [W-1:0] flags_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] set_m, clr_m;

    assign set_m = en_wr  ? en_bits  : '0;
    assign clr_m = dis_wr ? dis_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_o <= '0;
        else        mask_o <= (mask_o | set_m) & ~clr_m;
    end

    assign irq_o = |(flags_i & mask_o);
endmodule

// File: rtl/tcs_event_unit.sv
module tcs_event_unit
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wave_mode,
    input  logic              ev_wrap,
    input  logic              ev_cmp_a,
    input  logic              ev_cmp_b,
    input  logic              ev_cmp_c,
    input  logic              ev_cap_a,
    input  logic              ev_cap_b,
    input  logic              ev_trig,
    input  logic              rd_a,
    input  logic              rd_b,
    input  logic              rd_status,
    input  logic              clk_en_live,
    input  logic              io_a_lvl,
    input  logic              io_b_lvl,
    input  logic              ien_wr,
    input  logic [EVT_W-1:0]  ien_data,
    input  logic              idis_wr,
    input  logic [EVT_W-1:0]  idis_data,
    output logic [STAT_W-1:0] status_o,
    output logic [EVT_W-1:0]  mask_o,
    output logic              irq_o
);
    localparam int NTRK = 2;

    logic [NTRK-1:0] cap_ev, rd_ev, ovr_ev, pend;
    logic [EVT_W-1:0] set_vec, flags, vis_mask, vis_flags;

    // Capture strobes only count in capture mode
    assign cap_ev = wave_mode ? '0 : {ev_cap_b, ev_cap_a};
    assign rd_ev  = {rd_b, rd_a};

    for (genvar t = 0; t < NTRK; t++) begin : g_trk
        tcs_load_tracker u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (cap_ev[t]),
            .read_i    (rd_ev[t]),
            .overrun_o (ovr_ev[t]),
            .pending_o (pend[t])
        );
    end

    always_comb begin
        set_vec         = '0;
        set_vec[B_WRAP] = ev_wrap;
        set_vec[B_OVR]  = |ovr_ev;
        set_vec[B_CMPA] = ev_cmp_a & wave_mode;
        set_vec[B_CMPB] = ev_cmp_b & wave_mode;
        set_vec[B_CMPC] = ev_cmp_c;
        set_vec[B_CAPA] = cap_ev[0];
        set_vec[B_CAPB] = cap_ev[1];
        set_vec[B_TRIG] = ev_trig;
    end

    tcs_flag_bank #(.W(EVT_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (rd_status),
        .flag_o (flags)
    );

    // Mode-dependent visibility of stored flags
    always_comb begin
        vis_mask = '1;
        if (wave_mode) begin
            vis_mask[B_OVR]  = 1'b0;
            vis_mask[B_CAPA] = 1'b0;
            vis_mask[B_CAPB] = 1'b0;
        end else begin
            vis_mask[B_CMPA] = 1'b0;
            vis_mask[B_CMPB] = 1'b0;
        end
    end

    assign vis_flags = flags & vis_mask;

    tcs_irq_mask #(.W(EVT_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (ien_wr),
        .en_bits  (ien_data),
        .dis_wr   (idis_wr),
        .dis_bits (idis_data),
        .flags_i  (vis_flags),
        .mask_o   (mask_o),
        .irq_o    (irq_o)
    );

    always_comb begin
        status_o              = '0;
        status_o[EVT_W-1:0]   = vis_flags;
        status_o[B_CKEN]      = clk_en_live;
        status_o[B_IOA]       = io_a_lvl;
        status_o[B_IOB]       = io_b_lvl;
    end

    logic unused_pend;
    assign unused_pend = ^pend;
endmodule

// File: rtl/tcs_event_chk.sv
module tcs_event_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wave_mode,
    input logic        ev_wrap,
    input logic        ev_trig,
    input logic        ev_cmp_a,
    input logic        ev_cmp_b,
    input logic        ev_cmp_c,
    input logic        ev_cap_a,
    input logic        ev_cap_b,
    input logic        rd_status,
    input logic        ien_wr,
    input logic [7:0]  ien_data,
    input logic        idis_wr,
    input logic [18:0] status_o,
    input logic [7:0]  mask_o,
    input logic        irq_o
);
    logic any_ev;
    assign any_ev = ev_wrap | ev_trig | ev_cmp_a | ev_cmp_b | ev_cmp_c | ev_cap_a | ev_cap_b;

    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |=> status_o[0]); // R2
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !any_ev) |=> (status_o[7:0] == 8'h00)); // R3
    AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && ev_trig) |=> status_o[7]); // R4
    AST_CMP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_mode |-> (status_o[3:2] == 2'b00)); // R5
    AST_CAP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        wave_mode |-> (status_o[6:5] == 2'b00 && !status_o[1])); // R6
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !idis_wr) |=> ((mask_o & $past(ien_data)) == $past(ien_data))); // R9
    AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == 8'h00) |-> !irq_o); // R10
endmodule

bind tcs_event_unit tcs_event_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .ev_wrap(ev_wrap),
    .ev_trig(ev_trig), .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b),
    .ev_cmp_c(ev_cmp_c), .ev_cap_a(ev_cap_a), .ev_cap_b(ev_cap_b),
    .rd_status(rd_status), .ien_wr(ien_wr), .ien_data(ien_data),
    .idis_wr(idis_wr), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/tcs_event_unit_bench.sv
module tcs_event_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wave_mode = 0, ev_wrap = 0, ev_cmp_a = 0, ev_cmp_b = 0, ev_cmp_c = 0;
    logic ev_cap_a = 0, ev_cap_b = 0, ev_trig = 0, rd_a = 0, rd_b = 0, rd_status = 0;
    logic clk_en_live = 0, io_a_lvl = 0, io_b_lvl = 0, ien_wr = 0, idis_wr = 0;
    logic [7:0] ien_data = 0, idis_data = 0;
    logic [18:0] status_o;
    logic [7:0] mask_o;
    logic irq_o;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tcs_event_unit u_tcs_event_unit (.*);

    // {wave, rd_status, wrap,cmpA,cmpB,cmpC,capA,capB,trig, rdA,rdB, expected[7:0]}
    localparam int NV = 21;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0,1'b0,7'b1000000,2'b00,8'h01}, // R2 wrap
        {1'b0,1'b0,7'b0001001,2'b00,8'h91}, // R2 R11 cmpC + trig
        {1'b0,1'b1,7'b0000000,2'b00,8'h00}, // R3 clear
        {1'b0,1'b0,7'b0000100,2'b00,8'h20}, // R6 capA
        {1'b0,1'b0,7'b0000100,2'b00,8'h22}, // R7 second capA -> overrun
        {1'b0,1'b1,7'b0000000,2'b10,8'h00}, // R3 R7 clear + read A
        {1'b0,1'b0,7'b0000100,2'b00,8'h20}, // R7 no overrun after read
        {1'b0,1'b1,7'b0000010,2'b00,8'h40}, // R4 capB during status read
        {1'b0,1'b0,7'b0000100,2'b10,8'h60}, // R7 load with read same cycle
        {1'b0,1'b0,7'b0110000,2'b00,8'h60}, // R5 cmpA/B ignored in capture
        {1'b0,1'b1,7'b0000000,2'b00,8'h00},
        {1'b1,1'b0,7'b0110110,2'b00,8'h0C}, // R5 R6 wave mode
        {1'b1,1'b0,7'b1001001,2'b00,8'h9D}, // R11 in wave mode
        {1'b1,1'b1,7'b0000000,2'b00,8'h00},
        {1'b1,1'b0,7'b0000100,2'b00,8'h00}, // R6 capture ignored in wave
        {1'b0,1'b0,7'b0000010,2'b00,8'h42}, // R7 capB overrun
        {1'b0,1'b1,7'b0000000,2'b01,8'h00},
        {1'b0,1'b0,7'b0000010,2'b00,8'h40}, // R7 no overrun after read B
        {1'b1,1'b0,7'b0000000,2'b00,8'h00}, // R6 hidden in wave
        {1'b0,1'b0,7'b0000000,2'b00,8'h40}, // R6 visible again
        {1'b0,1'b1,7'b0000000,2'b00,8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        {ev_wrap, ev_cmp_a, ev_cmp_b, ev_cmp_c, ev_cap_a, ev_cap_b, ev_trig} = '0;
        {rd_a, rd_b, rd_status, ien_wr, idis_wr} = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle_all();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            finish_run();
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(status_o[7:0] == 8'h00, "R1 flags", status_o[7:0], 0);
        chk(mask_o == 8'h00, "R1 mask", mask_o, 0);
        chk(irq_o == 1'b0, "R1 irq", irq_o, 0);

        for (int i = 0; i < NV; i++) begin
            wave_mode = VEC[i][18];
            rd_status = VEC[i][17];
            {ev_wrap, ev_cmp_a, ev_cmp_b, ev_cmp_c, ev_cap_a, ev_cap_b, ev_trig} = VEC[i][16:10];
            {rd_a, rd_b} = VEC[i][9:8];
            tick();
            chk(status_o[7:0] == VEC[i][7:0],
                $sformatf("R2 R3 R4 R5 R6 R7 R11 row %0d", i), status_o[7:0], VEC[i][7:0]);
        end
        wave_mode = 1'b0;

        // R8 live bits
        clk_en_live = 1; io_a_lvl = 0; io_b_lvl = 1; #1;
        chk(status_o[18:8] == 11'b101_0000_0000, "R8 live 101", status_o[18:8], 11'h500);
        clk_en_live = 0; io_a_lvl = 1; io_b_lvl = 0; #1;
        chk(status_o[18:8] == 11'b010_0000_0000, "R8 live 010", status_o[18:8], 11'h200);

        // R9 mask set / clear
        ien_wr = 1; ien_data = 8'h81; tick();
        chk(mask_o == 8'h81, "R9 enable", mask_o, 8'h81);
        ien_wr = 1; ien_data = 8'h00; tick();
        chk(mask_o == 8'h81, "R9 zero enable", mask_o, 8'h81);
        idis_wr = 1; idis_data = 8'h01; tick();
        chk(mask_o == 8'h80, "R9 disable", mask_o, 8'h80);
        ien_wr = 1; ien_data = 8'h02; idis_wr = 1; idis_data = 8'h02; tick();
        chk(mask_o == 8'h80, "R9 disable wins", mask_o, 8'h80);

        // R10 interrupt
        ev_wrap = 1; tick();
        chk(irq_o == 1'b0, "R10 unmasked flag", irq_o, 0);
        ev_trig = 1; tick();
        chk(irq_o == 1'b1, "R10 masked flag", irq_o, 1);
        rd_status = 1; tick();
        chk(irq_o == 1'b0, "R10 after clear", irq_o, 0);

        // R1 reset again clears state
        ien_wr = 1; ien_data = 8'hFF; ev_cap_a = 1; tick();
        rst_n = 0; #1;
        chk(status_o[7:0] == 8'h00 && mask_o == 8'h00, "R1 async reset",
            {status_o[7:0], mask_o}, 0);
        @(posedge clk); #1 rst_n = 1;
        ev_cap_a = 1; tick();
        chk(status_o[7:0] == 8'h20, "R1 tracker idle after reset", status_o[7:0], 8'h20);

        done = 1;
        finish_run();
    end
endmodule